// File: doc/BRIEF.md
# Accumulator Processor Core with Multi-Cycle Fetch and Execute

This block is a small processor that keeps its working value in a single accumulator and talks to one synchronous memory through a shared port. The program counter, address register, data register, instruction register and accumulator are separate registers. A control state machine moves words between them one step at a time. Every memory access, whether it fetches an instruction, reads an operand or stores a result, goes out through the address register and the data register.

Memory has one cycle of read latency. A read strobe in one cycle makes the word available on the read-data input in the next cycle, and it is captured in that cycle. Between instructions the core can lend the memory port to another master. That master raises a request, and the core answers with a grant once it reaches the next fetch boundary. The core keeps its strobes low until the request is withdrawn.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, both strobes and the grant stay low. After reset the program counter, accumulator and all other registers are zero, so the first instruction read targets address 0.
- R2: Fetch runs over four cycles. In the first, the program counter is copied into the address register. In the second, the read strobe is raised at that address and the program counter is incremented. In the third, the returned word is captured into the data register. In the fourth, it moves into the instruction register. Execution starts in the fifth cycle.
- R3: An instruction word is 16 bits wide. Bits [15:12] are the opcode and bits [11:0] are the operand, so the address space holds 4096 words.
- R4: Opcodes 1 (load), 4 (add), 5 (subtract, accumulator minus memory), 6 (and) and 7 (or) first copy the operand into the address register. They then read memory at that address. The word is captured one cycle later, and the accumulator is updated in the following cycle. Arithmetic wraps modulo 2^16.
- R5: Opcode 2 places the zero-extended operand in the data register and then copies it into the accumulator. It makes no memory access.
- R6: Opcode 3 copies the operand into the address register and the accumulator into the data register. In the next cycle it raises the write strobe with that address and data. Read and write strobes are never high together.
- R7: Opcodes 8 and 9 shift the accumulator one place left or right (logical shift, zero fill). The operand is ignored and there is no memory access.
- R8: Opcode 10 loads the operand into the program counter. Opcode 11 does the same only when the accumulator is zero, and otherwise falls through.
- R9: Opcode 15 stops the core. No further strobe or grant is issued until reset. Opcodes 0, 12, 13 and 14 do nothing beyond their fetch.
- R10: A bus request is granted only at a fetch boundary, before the program counter is copied into the address register. The grant is held for as long as the request stays high. Fetch resumes in the cycle after the first cycle in which the request is seen low.
- R11: While the grant is high, neither the read strobe nor the write strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 12 | Memory address, taken from the address register |
| memWdata | output | 16 | Write data, taken from the data register |
| memRdata | input | 16 | Read data, valid one cycle after the read strobe |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| busReq | input | 1 | External request for the memory port |
| busGnt | output | 1 | Memory port handed to the external master |

## Verification
The bench runs a program that covers every opcode. It wraps a subtraction below zero, shifts a one out of the top bit, and takes one conditional jump while skipping another. A core that sampled read data in the strobe cycle, or incremented the program counter late, would fetch from the wrong address at once. A wrong jump condition would send the store trace to the wrong locations.

Bus requests are applied in several ways:
- held through reset release;
- raised in the middle of an instruction;
- pulsed for a single cycle;
- raised after the halt.

A core that granted mid-instruction, or released the port one cycle early or late, would show a shifted strobe trace. A core that woke up after halting would issue a store that the program places after the halt.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_LOADI = 4'd2,
    OP_STORE = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_SHL   = 4'd8,
    OP_SHR   = 4'd9,
    OP_JMP   = 4'd10,
    OP_JMPZ  = 4'd11,
    OP_HALT  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SHL,
    ALU_SHR
  } alu_op_e;

  typedef enum logic [3:0] {
    S_FADDR,
    S_FREAD,
    S_FCAP,
    S_DECODE,
    S_EXEC,
    S_MREAD,
    S_MCAP,
    S_ALU,
    S_MWRITE,
    S_GRANT,
    S_HALT
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    marFromPc;
    logic    marFromOpnd;
    logic    mdrFromMem;
    logic    mdrFromImm;
    logic    mdrFromAcc;
    logic    pcInc;
    logic    pcLoad;
    logic    cirLoad;
    logic    accLoad;
    alu_op_e aluOp;
  } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SHL: y = {a[W-2:0], 1'b0};
      ALU_SHR: y = {1'b0, a[W-1:1]};
      default: y = b;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctl_t                      ctl,
  input  logic [OPC_W+ADDR_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [OPC_W+ADDR_W-1:0]   memWdata,
  output logic [OPC_W-1:0]          opcode,
  output logic                      accZero
);

  localparam int DATA_W = OPC_W + ADDR_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] cir;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] aluY;
  logic [ADDR_W-1:0] operand;

  assign opcode  = cir[DATA_W-1 -: OPC_W];
  assign operand = cir[ADDR_W-1:0];
  assign accZero = (acc == '0);
  assign memAddr  = mar;
  assign memWdata = mdr;

  acc_alu #(.W(DATA_W)) u_alu (
    .op (ctl.aluOp),
    .a  (acc),
    .b  (mdr),
    .y  (aluY)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      if (ctl.pcLoad)      pc <= operand;
      else if (ctl.pcInc)  pc <= pc + 1'b1;

      if (ctl.marFromPc)        mar <= pc;
      else if (ctl.marFromOpnd) mar <= operand;

      if (ctl.mdrFromMem)      mdr <= memRdata;
      else if (ctl.mdrFromImm) mdr <= {{OPC_W{1'b0}}, operand};
      else if (ctl.mdrFromAcc) mdr <= acc;

      if (ctl.cirLoad) cir <= mdr;
      if (ctl.accLoad) acc <= aluY;
    end
  end

  // program counter advances by exactly one after a fetch read
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcInc |=> pc == $past(pc) + 1'b1);

  // the instruction register receives what the data register held
  p_cir_from_mdr_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cirLoad |=> cir == $past(mdr));

  // immediate value arrives with a clear opcode field
  p_imm_zero_ext_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mdrFromImm |=> mdr[DATA_W-1:ADDR_W] == '0);

  // a store presents the accumulator value one cycle later
  p_store_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mdrFromAcc |=> memWdata == $past(acc));

endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  input  logic             accZero,
  input  logic             busReq,
  output ctl_t             ctl,
  output logic             memRd,
  output logic             memWr,
  output logic             busGnt
);

  state_e state;
  state_e nextState;

  function automatic alu_op_e aluFor(input logic [OPC_W-1:0] op);
    case (op)
      OP_ADD:  return ALU_ADD;
      OP_SUB:  return ALU_SUB;
      OP_AND:  return ALU_AND;
      OP_OR:   return ALU_OR;
      OP_SHL:  return ALU_SHL;
      OP_SHR:  return ALU_SHR;
      default: return ALU_PASS;
    endcase
  endfunction

  always_comb begin
    ctl       = '0;
    ctl.aluOp = ALU_PASS;
    memRd     = 1'b0;
    memWr     = 1'b0;
    busGnt    = 1'b0;
    nextState = state;
    unique case (state)
      S_FADDR: begin
        if (busReq) begin
          nextState = S_GRANT;
        end else begin
          ctl.marFromPc = 1'b1;
          nextState     = S_FREAD;
        end
      end
      S_FREAD: begin
        memRd     = 1'b1;
        ctl.pcInc = 1'b1;
        nextState = S_FCAP;
      end
      S_FCAP: begin
        ctl.mdrFromMem = 1'b1;
        nextState      = S_DECODE;
      end
      S_DECODE: begin
        ctl.cirLoad = 1'b1;
        nextState   = S_EXEC;
      end
      S_EXEC: begin
        nextState = S_FADDR;
        case (opcode)
          OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR: begin
            ctl.marFromOpnd = 1'b1;
            nextState       = S_MREAD;
          end
          OP_LOADI: begin
            ctl.mdrFromImm = 1'b1;
            nextState      = S_ALU;
          end
          OP_STORE: begin
            ctl.marFromOpnd = 1'b1;
            ctl.mdrFromAcc  = 1'b1;
            nextState       = S_MWRITE;
          end
          OP_SHL, OP_SHR: begin
            ctl.accLoad = 1'b1;
            ctl.aluOp   = aluFor(opcode);
          end
          OP_JMP:  ctl.pcLoad = 1'b1;
          OP_JMPZ: ctl.pcLoad = accZero;
          OP_HALT: nextState  = S_HALT;
          default: nextState  = S_FADDR;
        endcase
      end
      S_MREAD: begin
        memRd     = 1'b1;
        nextState = S_MCAP;
      end
      S_MCAP: begin
        ctl.mdrFromMem = 1'b1;
        nextState      = S_ALU;
      end
      S_ALU: begin
        ctl.accLoad = 1'b1;
        ctl.aluOp   = aluFor(opcode);
        nextState   = S_FADDR;
      end
      S_MWRITE: begin
        memWr     = 1'b1;
        nextState = S_FADDR;
      end
      S_GRANT: begin
        busGnt    = 1'b1;
        nextState = busReq ? S_GRANT : S_FADDR;
      end
      S_HALT:  nextState = S_HALT;
      default: nextState = S_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FADDR;
    else       state <= nextState;
  end

  p_no_strobe_granted_r11: assert property (@(posedge clk) disable iff (!rstN)
    busGnt |-> (!memRd && !memWr));

  p_grant_at_boundary_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGnt) |-> $past(state) == S_FADDR);

  p_resume_fetch_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busGnt) |-> (state == S_FADDR && !$past(busReq)));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    state == S_HALT |=> (state == S_HALT && !memRd && !memWr && !busGnt));

  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [OPC_W+ADDR_W-1:0]  memWdata,
  input  logic [OPC_W+ADDR_W-1:0]  memRdata,
  output logic                     memRd,
  output logic                     memWr,
  input  logic                     busReq,
  output logic                     busGnt
);

  ctl_t             ctl;
  logic [OPC_W-1:0] opcode;
  logic             accZero;

  acc_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .accZero (accZero),
    .busReq  (busReq),
    .ctl     (ctl),
    .memRd   (memRd),
    .memWr   (memWr),
    .busGnt  (busGnt)
  );

  acc_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .accZero  (accZero)
  );

endmodule

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int RUN_CYCLES = 420;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic          memRd, memWr;
  logic          busReq = 1'b0;
  logic          busGnt;

  always #10 clk = ~clk;

  acc_core #(.ADDR_W(AW)) u_acc_core (
    .clk      (clk),
    .rstN     (rstN),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .memRd    (memRd),
    .memWr    (memWr),
    .busReq   (busReq),
    .busGnt   (busGnt)
  );

  logic [DW-1:0] mem    [0:(1<<AW)-1];
  logic [DW-1:0] refMem [0:(1<<AW)-1];

  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr];
    if (memWr) mem[memAddr] <= memWdata;
  end

  typedef struct packed {
    logic          st;
    logic          rd;
    logic          wr;
    logic          gnt;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } tok_t;

  tok_t  q[$];
  string tq[$];

  int nChecks = 0;
  int nFail   = 0;

  logic [AW-1:0] mPc  = '0;
  logic [DW-1:0] mAcc = '0;
  bit            mHalted = 0;

  function automatic tok_t mk(logic st, logic rd, logic wr, logic gnt,
                              logic [AW-1:0] a, logic [DW-1:0] d);
    tok_t t;
    t.st = st; t.rd = rd; t.wr = wr; t.gnt = gnt; t.addr = a; t.data = d;
    return t;
  endfunction

  task automatic push(tok_t t, string tag);
    q.push_back(t);
    tq.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(logic [3:0] op, logic [AW-1:0] o);
    return {op, o};
  endfunction

  // instruction-level reference: expands one instruction into per-cycle port tokens
  task automatic step();
    logic [DW-1:0] w;
    logic [3:0]    op;
    logic [AW-1:0] o;
    string         execTag;
    if (mHalted) begin
      push(mk(0,0,0,0,'0,'0), "R9");
      return;
    end
    w  = refMem[mPc];
    op = w[15:12];
    o  = w[11:0];
    push(mk(1,0,0,0,'0,'0), "R10");
    push(mk(0,1,0,0,mPc,'0), "R2");
    push(mk(0,0,0,0,'0,'0), "R2");
    push(mk(0,0,0,0,'0,'0), "R3");
    case (op)
      4'd8, 4'd9:         execTag = "R7";
      4'd10, 4'd11:       execTag = "R8";
      4'd0, 4'd12, 4'd13,
      4'd14, 4'd15:       execTag = "R9";
      default:            execTag = "R3";
    endcase
    push(mk(0,0,0,0,'0,'0), execTag);
    mPc = mPc + 1'b1;
    case (op)
      4'd1, 4'd4, 4'd5, 4'd6, 4'd7: begin
        push(mk(0,1,0,0,o,'0), "R4");
        push(mk(0,0,0,0,'0,'0), "R4");
        push(mk(0,0,0,0,'0,'0), "R4");
        case (op)
          4'd1:    mAcc = refMem[o];
          4'd4:    mAcc = mAcc + refMem[o];
          4'd5:    mAcc = mAcc - refMem[o];
          4'd6:    mAcc = mAcc & refMem[o];
          default: mAcc = mAcc | refMem[o];
        endcase
      end
      4'd2: begin
        push(mk(0,0,0,0,'0,'0), "R5");
        mAcc = {4'b0, o};
      end
      4'd3: begin
        push(mk(0,0,1,0,o,mAcc), "R6");
        refMem[o] = mAcc;
      end
      4'd8:  mAcc = mAcc << 1;
      4'd9:  mAcc = mAcc >> 1;
      4'd10: mPc = o;
      4'd11: if (mAcc == '0) mPc = o;
      4'd15: mHalted = 1;
      default: ;
    endcase
  endtask

  function automatic bit reqAt(int c);
    return (c < 4) || (c >= 40 && c < 43) || (c == 70) ||
           (c >= 120 && c < 127) || (c >= 380 && c < 390);
  endfunction

  task automatic loadProgram();
    for (int i = 0; i < (1 << AW); i++) refMem[i] = '0;
    refMem[12'h000] = enc(4'd2,  12'h123);   // immediate load
    refMem[12'h001] = enc(4'd3,  12'h100);
    refMem[12'h002] = enc(4'd4,  12'h200);
    refMem[12'h003] = enc(4'd5,  12'h201);
    refMem[12'h004] = enc(4'd6,  12'h202);
    refMem[12'h005] = enc(4'd7,  12'h203);
    refMem[12'h006] = enc(4'd8,  12'hFFF);   // operand ignored
    refMem[12'h007] = enc(4'd9,  12'hABC);
    refMem[12'h008] = enc(4'd3,  12'h101);
    refMem[12'h009] = enc(4'd11, 12'h040);   // not taken
    refMem[12'h00A] = enc(4'd12, 12'h000);   // undefined -> nothing
    refMem[12'h00B] = enc(4'd1,  12'h204);
    refMem[12'h00C] = enc(4'd11, 12'h020);   // taken
    refMem[12'h00D] = enc(4'd15, 12'h000);   // skipped
    refMem[12'h020] = enc(4'd1,  12'h206);
    refMem[12'h021] = enc(4'd8,  12'h000);   // msb shifted out
    refMem[12'h022] = enc(4'd3,  12'h102);
    refMem[12'h023] = enc(4'd5,  12'h207);   // wraps below zero
    refMem[12'h024] = enc(4'd3,  12'h103);
    refMem[12'h025] = enc(4'd9,  12'h000);
    refMem[12'h026] = enc(4'd3,  12'h104);
    refMem[12'h027] = enc(4'd10, 12'h030);
    refMem[12'h028] = enc(4'd15, 12'h000);   // skipped
    refMem[12'h030] = enc(4'd13, 12'h555);
    refMem[12'h031] = enc(4'd14, 12'h000);
    refMem[12'h032] = enc(4'd0,  12'h000);
    refMem[12'h033] = enc(4'd3,  12'h105);
    refMem[12'h034] = enc(4'd15, 12'h000);
    refMem[12'h035] = enc(4'd3,  12'h106);   // must never run
    refMem[12'h200] = 16'h0F0F;
    refMem[12'h201] = 16'h0032;
    refMem[12'h202] = 16'hF0F0;
    refMem[12'h203] = 16'h00FF;
    refMem[12'h204] = 16'h0000;
    refMem[12'h206] = 16'h8001;
    refMem[12'h207] = 16'h0003;
    refMem[12'h106] = 16'h5A5A;
    for (int i = 0; i < (1 << AW); i++) mem[i] = refMem[i];
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", nChecks, RUN_CYCLES);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    tok_t  t;
    string tg;
    loadProgram();
    repeat (3) begin
      @(negedge clk);
      check(!memRd && !memWr && !busGnt, "R1", "strobes during reset",
            {29'b0, memRd, memWr, busGnt}, 32'h0);
    end
    for (int c = 0; c < RUN_CYCLES; c++) begin
      @(negedge clk);
      if (c == 0) rstN = 1'b1;
      while (q.size() == 0) step();
      t  = q.pop_front();
      tg = tq.pop_front();
      if (c == 1) tg = "R1";   // the cycle after a granted first boundary
      check({memRd, memWr, busGnt,
             (t.rd || t.wr) ? memAddr : 12'h0,
             t.wr ? memWdata : 16'h0}
            == {t.rd, t.wr, t.gnt, t.addr, t.data},
            t.gnt ? "R11" : tg, "port trace",
            {1'b0, memRd, memWr, busGnt, (t.rd || t.wr) ? memAddr : 12'h0,
             t.wr ? memWdata : 16'h0},
            {1'b0, t.rd, t.wr, t.gnt, t.addr, t.data});
      busReq = reqAt(c);
      if ((t.st || t.gnt) && busReq) begin
        q.push_front(mk(0,0,0,1,'0,'0));
        tq.push_front("R10");
      end else if (t.gnt) begin
        q.push_front(mk(1,0,0,0,'0,'0));
        tq.push_front("R10");
      end
    end
    check(mHalted, "R9", "program reached halt", {31'b0, mHalted}, 32'h1);
    for (int a = 12'h100; a <= 12'h106; a++) begin
      check(mem[a] == refMem[a], "R6", "stored word",
            {16'h0, mem[a]}, {16'h0, refMem[a]});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule